// File: doc/BRIEF.md
# Multi-Source Interrupt Request Combiner

This block merges up to eight peripheral event sources into one maskable interrupt request for a processor. Each source raises a sticky flag with a single-cycle pulse. A parallel mask register selects the flags that may request service. The request bit is never stored. It is computed live as the OR, over all sources, of flag AND mask. It falls as soon as no source has both its flag and its mask bit set, whether or not the request was ever serviced.

A control register holds a 3-bit priority level. It also returns the live request bit as a read-only field. The output to the processor is raised only when four conditions hold: the global interrupt enable is on, the request bit is 1, the level is non-zero, and the level is strictly above the processor's current priority level. Acknowledge clears nothing. The interrupt routine reads the flag register to find the active sources. It then clears their flags by writing ones to them.

Top module: `irq_agg`

## Requirements
- R1: `req_o` is 1 in the cycle after any clock edge that leaves at least one source with both its flag bit (address 0) and its mask bit (address 1) set to 1.
- R2: `req_o` drops to 0 right after the edge at which, for every source, the flag or the mask bit becomes 0. This holds even if the request was never acknowledged. Flags left set raise `req_o` again when the mask is restored.
- R3: Writing to the request field of the control register (address 2, bit 3) has no effect. The field always reads the live request value.
- R4: Pulsing `ack_i` leaves every flag bit unchanged.
- R5: Pulsing `ack_i` leaves `req_o` unchanged.
- R6: When more sources raise flags while `req_o` is already 1, `req_o` stays 1 with no low cycle, and the flag register shows every active source.
- R7: A one-cycle pulse on `evt_i[i]` sets flag bit i at that edge. Writing 1 to bit i of address 0 clears it, and writing 0 leaves it unchanged. If a pulse and a clearing write hit the same bit in the same cycle, the flag ends up set.
- R8: `irq_o` is registered. It equals, one cycle later, `gie_i` AND `req_o` AND (level != 0) AND (level > `cpu_ipl_i`). The level is control bits [2:0].
- R9: Synchronous reset clears the flags, the mask, the level, `req_o`, `irq_o` and `bus_rdata`.
- R10: Reads are registered: `bus_rdata` takes the addressed register at the edge where `bus_rd` is 1 and holds its value otherwise. Bits of the control register above bit 3 read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 flags, 1 mask, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_i | input | 8 | Per-source one-cycle event pulses |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| gie_i | input | 1 | Global interrupt enable flag |
| cpu_ipl_i | input | 3 | Current processor priority level |
| req_o | output | 1 | Live combined request bit |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
A table of vectors drives the combining logic with several kinds of input. In some, the events and the mask do not overlap; in others they overlap on one bit or on several. Separate vectors hold the level equal to, below and above the processor level, set the level to zero, and turn off the global enable. Together these separate a faulty AND-OR from a faulty priority compare. Directed sequences cover the cases that need more than one register: a flag set and cleared in the same cycle, a write to the read-only request field, acknowledge pulses with the request held high, a second source arriving during an active request, and removing the mask and restoring it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_FLAGS = 0;
  localparam int ADDR_MASK  = 1;
  localparam int ADDR_CTRL  = 2;
  localparam int REQ_BIT    = 3;
endpackage

// File: rtl/irq_agg_flags.sv
module irq_agg_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else if (evt[i])
        flags[i] <= 1'b1;
      else if (clr_we && wdata[i])
        flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask <= '0;
    else if (mask_we)
      mask <= wdata;
  end
endmodule

// File: rtl/irq_agg_ctl.sv
module irq_agg_ctl #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [LW-1:0] wlevel,
  output logic [LW-1:0] level
);
  always_ff @(posedge clk) begin
    if (rst)
      level <= '0;
    else if (we)
      level <= wlevel;
  end
endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gie,
  input  logic          req,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] cpu_ipl,
  output logic          irq
);
  logic take;
  assign take = gie && req && (level != '0) && (level > cpu_ipl);

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= take;
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  evt_i,
  input  logic          ack_i,
  input  logic          gie_i,
  input  logic [LW-1:0] cpu_ipl_i,
  output logic          req_o,
  output logic          irq_o
);
  localparam int PAD = DW - N;

  logic [N-1:0]  flags;
  logic [N-1:0]  mask;
  logic [LW-1:0] level;
  logic          sel_flags, sel_mask, sel_ctrl;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] ctrl_view;

  assign sel_flags = (bus_addr == AW'(ADDR_FLAGS));
  assign sel_mask  = (bus_addr == AW'(ADDR_MASK));
  assign sel_ctrl  = (bus_addr == AW'(ADDR_CTRL));

  irq_agg_flags #(.N(N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_i),
    .clr_we  (bus_wr && sel_flags),
    .mask_we (bus_wr && sel_mask),
    .wdata   (bus_wdata[N-1:0]),
    .flags   (flags),
    .mask    (mask)
  );

  irq_agg_ctl #(.LW(LW)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_wr && sel_ctrl),
    .wlevel (bus_wdata[LW-1:0]),
    .level  (level)
  );

  assign req_o = |(flags & mask);

  irq_agg_gate #(.LW(LW)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .gie     (gie_i),
    .req     (req_o),
    .level   (level),
    .cpu_ipl (cpu_ipl_i),
    .irq     (irq_o)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[LW-1:0] = level;
    ctrl_view[REQ_BIT] = req_o;
  end

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        if (sel_flags)     rd_mux = {{PAD{1'b0}}, flags};
        else if (sel_mask) rd_mux = {{PAD{1'b0}}, mask};
        else if (sel_ctrl) rd_mux = ctrl_view;
        else               rd_mux = '0;
      end
    end else begin : g_nopad
      always_comb begin
        if (sel_flags)     rd_mux = flags;
        else if (sel_mask) rd_mux = mask;
        else if (sel_ctrl) rd_mux = ctrl_view;
        else               rd_mux = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  evt_i,
  input logic          ack_i,
  input logic          gie_i,
  input logic [LW-1:0] cpu_ipl_i,
  input logic          req_o,
  input logic          irq_o,
  input logic [N-1:0]  flags,
  input logic [N-1:0]  mask,
  input logic [LW-1:0] level
);
  // R7
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R4
  ack_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !bus_wr && evt_i == '0) |=> $stable(flags));

  // R5
  ack_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_o && !bus_wr && evt_i == '0) |=> req_o);

  // R3
  ctrl_write_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(2) && evt_i == '0) |=> $stable(req_o));

  // R2
  all_clear_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(0) && bus_wdata[N-1:0] == '1 && evt_i == '0) |=> !req_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(gie_i && req_o && level != '0 && level > cpu_ipl_i)));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && mask == '0 && level == '0 && !irq_o));
endmodule

bind irq_agg irq_agg_chk #(.N(N), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .evt_i     (evt_i),
  .ack_i     (ack_i),
  .gie_i     (gie_i),
  .cpu_ipl_i (cpu_ipl_i),
  .req_o     (req_o),
  .irq_o     (irq_o),
  .flags     (flags),
  .mask      (mask),
  .level     (level)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] evt_i = '0;
  logic       ack_i = 1'b0;
  logic       gie_i = 1'b0;
  logic [2:0] cpu_ipl_i = '0;
  logic       req_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_agg dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .ack_i(ack_i),
    .gie_i(gie_i), .cpu_ipl_i(cpu_ipl_i), .req_o(req_o), .irq_o(irq_o)
  );

  // vector: {evt[7:0], mask[7:0], level[2:0], gie, ipl[2:0]}
  localparam logic [22:0] VEC [10] = '{
    {8'h01, 8'h01, 3'd3, 1'b1, 3'd1},
    {8'h02, 8'h01, 3'd3, 1'b1, 3'd1},
    {8'hA0, 8'h80, 3'd7, 1'b1, 3'd6},
    {8'h0F, 8'hF0, 3'd7, 1'b1, 3'd0},
    {8'h18, 8'h3C, 3'd4, 1'b1, 3'd4},
    {8'h18, 8'h3C, 3'd4, 1'b1, 3'd5},
    {8'h40, 8'h40, 3'd0, 1'b1, 3'd0},
    {8'h40, 8'h40, 3'd5, 1'b0, 3'd0},
    {8'hFF, 8'hFF, 3'd1, 1'b1, 3'd0},
    {8'h00, 8'hFF, 3'd7, 1'b1, 3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic       ereq, eirq;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 req", req_o, 0);
    check("R9 irq", irq_o, 0);
    check("R9 rdata", bus_rdata, 0);
    rd(2'd0, d); check("R9 flags", d, 0);
    rd(2'd1, d); check("R9 mask", d, 0);
    rd(2'd2, d); check("R9 ctrl", d, 0);

    // table walk: R1, R2, R8
    for (int i = 0; i < 10; i++) begin
      logic [7:0] ve, vm;
      logic [2:0] vl, vp;
      logic       vg;
      {ve, vm, vl, vg, vp} = VEC[i];
      wr(2'd0, 8'hFF);
      wr(2'd1, vm);
      wr(2'd2, {5'b0, vl});
      gie_i = vg; cpu_ipl_i = vp;
      pulse(ve);
      @(negedge clk);
      ereq = |(ve & vm);
      eirq = vg && ereq && (vl != 0) && (vl > vp);
      check("R1 req from table", req_o, ereq);
      check("R8 irq from table", irq_o, eirq);
    end

    // R2 clear all flags, unacknowledged request drops
    wr(2'd0, 8'hFF);
    check("R2 req after clear", req_o, 0);
    @(negedge clk);
    check("R8 irq after clear", irq_o, 0);

    // R2 mask removal and restore
    wr(2'd1, 8'h04);
    pulse(8'h04);
    check("R1 req set", req_o, 1);
    wr(2'd1, 8'h00);
    check("R2 req masked off", req_o, 0);
    wr(2'd1, 8'h04);
    check("R2 req back with mask", req_o, 1);

    // R3 write to request field ignored
    wr(2'd2, 8'h05);
    check("R3 req after ctrl write 0", req_o, 1);
    rd(2'd2, d); check("R3 ctrl read", d, 8'h0D);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'hFF);
    check("R3 req after ctrl write 1", req_o, 0);
    rd(2'd2, d); check("R10 ctrl upper bits 0", d, 8'h07);

    // R4 R5 acknowledge clears nothing
    pulse(8'h04);
    @(negedge clk); ack_i = 1'b1;
    repeat (3) @(negedge clk);
    ack_i = 1'b0;
    check("R5 req after ack", req_o, 1);
    rd(2'd0, d); check("R4 flags after ack", d, 8'h04);

    // R6 second source during active request
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h0F);
    pulse(8'h01);
    check("R6 first source", req_o, 1);
    @(negedge clk); evt_i = 8'h02;
    @(posedge clk); #1 check("R6 no low cycle", req_o, 1);
    @(negedge clk); evt_i = 8'h00;
    check("R6 req held", req_o, 1);
    rd(2'd0, d); check("R6 flags show both", d, 8'h03);

    // R7 partial write-1-to-clear, write 0 no effect
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R7 write zero keeps", d, 8'h03);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R7 w1c one bit", d, 8'h02);

    // R7 set wins over clear in same cycle
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h20; bus_wr = 1'b1; evt_i = 8'h20;
    @(negedge clk);
    bus_wr = 1'b0; evt_i = 8'h00;
    rd(2'd0, d); check("R7 set wins", d, 8'h22);

    // R10 unmapped address and hold behaviour
    rd(2'd3, d); check("R10 addr3 reads 0", d, 0);
    rd(2'd1, d); check("R10 mask read", d, 8'h0F);
    pulse(8'h08);
    check("R10 rdata held without rd", bus_rdata, 8'h0F);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 req after reset", req_o, 0);
    check("R9 irq after reset", irq_o, 0);
    rd(2'd1, d); check("R9 mask after reset", d, 0);

    finish_run();
  end
endmodule